// File: doc/BRIEF.md
# Sector Protection Control Unit

This unit guards the erase and program paths of a 512 KB (19-bit byte address) nonvolatile array. It keeps one protection bit per physical sector and decides whether a requested program or erase may go ahead. The sectors are not all the same size. The lower part of the array is split into equal 64 KB sectors. The top 64 KB is split more finely, into one 32 KB sector, two 8 KB sectors and one 16 KB sector at the very top. This gives eleven sectors in all.

Software-level command logic drives simple one-cycle request strobes into the unit:
- protect or unprotect a single sector, selected by any byte address inside it;
- protect or unprotect every sector at once.

An active-low write-protect pin freezes protected sectors: while it is low, nothing can be unprotected. New protection is still accepted.

A check strobe carries an operation code and an address. One cycle later the unit answers allow or deny. A denial also raises a sticky error flag, which stays set until it is explicitly cleared. The unit also reports, combinationally, the index and the protection state of the sector that contains the check address. The command layer can use this as its status read-back.

Top module: `sector_lock_unit`

## Requirements
- R1: After reset all eleven sectors are protected, `err_flag` is 0 and `res_valid` is 0.
- R2: `sect_idx` gives the sector holding `chk_addr`, and `sect_prot` gives that sector's protection bit. The sectors are:
  - sectors 0..6 are 0x00000–0x6FFFF, in 64 KB steps;
  - sector 7 is 0x70000–0x77FFF;
  - sector 8 is 0x78000–0x79FFF;
  - sector 9 is 0x7A000–0x7BFFF;
  - sector 10 is 0x7C000–0x7FFFF.
- R3: A `sect_prot_req` pulse sets the bit of the sector holding `sect_addr` from the next cycle on. All other bits are left unchanged.
- R4: A `sect_unprot_req` pulse with `wp_n` high clears only the bit of the sector holding `sect_addr`.
- R5: `all_prot_req` sets all eleven bits. `all_unprot_req` with `wp_n` high clears all eleven bits.
- R6: While `wp_n` is low, single and global unprotect requests have no effect. Protect requests still take effect.
- R7: When several requests arrive in the same cycle, precedence runs in this order:
  - global protect;
  - then an effective global unprotect;
  - then single protect;
  - then an effective single unprotect.
- R8: `chk_op` 0 is a program and `chk_op` 1 is a 4 KB erase. For either, a `chk_req` pulse gives a one-cycle `res_valid` on the next cycle. `res_allow` is 1 exactly when the sector holding `chk_addr` is unprotected. `res_allow` is never high without `res_valid`.
- R9: `chk_op` 2 is a 32 KB block erase and `chk_op` 3 is a 64 KB block erase. The block is the aligned one holding `chk_addr`. The request is denied if any sector overlapping that block is protected.
- R10: `chk_op` 4 is a full-array erase, and codes 5–7 are treated the same way. It is denied if any sector is protected.
- R11: Every denial sets `err_flag`. The flag holds until an `err_clr` pulse. A denial in the same cycle as `err_clr` leaves the flag set.
- R12: A check is judged against the protection bits as they stood before any protect or unprotect request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect pin, low locks protected sectors |
| sect_prot_req | input | 1 | Protect the sector holding `sect_addr` |
| sect_unprot_req | input | 1 | Unprotect the sector holding `sect_addr` |
| sect_addr | input | 19 | Byte address selecting the sector for single requests |
| all_prot_req | input | 1 | Protect every sector |
| all_unprot_req | input | 1 | Unprotect every sector |
| chk_req | input | 1 | Ask whether an operation may proceed |
| chk_op | input | 3 | Operation kind (0 program, 1/2/3 erase 4/32/64 KB, 4–7 full array) |
| chk_addr | input | 19 | Target byte address of the checked operation and of the status read |
| err_clr | input | 1 | Clear the sticky error flag |
| sect_idx | output | 4 | Index of the sector holding `chk_addr` |
| sect_prot | output | 1 | Protection bit of that sector |
| res_valid | output | 1 | Check result valid, one cycle after `chk_req` |
| res_allow | output | 1 | Operation may proceed |
| err_flag | output | 1 | Sticky denial flag |

## Verification
Any wrong protection bit can be seen at once, with no clock edge, on `sect_prot`, by steering `chk_addr` into the affected sector. The bench walks all sectors this way after every state change. A sector decode that is off at a boundary (for example, at 0x77FFF versus 0x78000, or at 0x7BFFF versus 0x7C000) appears as a wrong `sect_idx` in the same cycle. A wrong block-span decode appears only as a wrong `res_allow` one cycle after a block or full-array check. So the spans are probed with a single protected sector placed just inside and just outside each block. A lost or stuck error bit shows on `err_flag` on the cycle after the denial or clear.

// File: rtl/sector_lock_pkg.sv
package sector_lock_pkg;

  localparam int ADDR_W   = 19;
  localparam int NSECT    = 11;
  localparam int SIDX_W   = $clog2(NSECT);
  localparam int BIG_SZ   = 65536;
  localparam int NBIG     = (1 << ADDR_W) / BIG_SZ - 1;
  localparam int SMALL_SZ = 4096;

  typedef enum logic [2:0] {
    OP_PROG  = 3'd0,
    OP_ER4K  = 3'd1,
    OP_ER32K = 3'd2,
    OP_ER64K = 3'd3,
    OP_CHIP  = 3'd4
  } op_e;

  // Size of sector i: large uniform sectors first, then a half, two eighths, a quarter.
  function automatic logic [31:0] sect_size(int i);
    if (i < NBIG)           return 32'(BIG_SZ);
    else if (i == NBIG)     return 32'(BIG_SZ / 2);
    else if (i == NBIG + 3) return 32'(BIG_SZ / 4);
    else                    return 32'(BIG_SZ / 8);
  endfunction

  // Lowest byte address of sector i, the running sum of the sizes below it.
  function automatic logic [31:0] sect_lo(int i);
    logic [31:0] acc;
    acc = '0;
    for (int k = 0; k < i; k++) acc = acc + sect_size(k);
    return acc;
  endfunction

  function automatic logic [31:0] sect_hi(int i);
    return sect_lo(i) + sect_size(i) - 32'd1;
  endfunction

  // Bytes covered by an operation, the block is aligned to its own size.
  function automatic logic [31:0] blk_bytes(logic [2:0] op);
    case (op)
      OP_PROG:  return 32'd1;
      OP_ER4K:  return 32'(SMALL_SZ);
      OP_ER32K: return 32'(BIG_SZ / 2);
      OP_ER64K: return 32'(BIG_SZ);
      default:  return 32'(1 << ADDR_W);
    endcase
  endfunction

  function automatic logic [SIDX_W-1:0] onehot_to_idx(logic [NSECT-1:0] oh);
    logic [SIDX_W-1:0] r;
    r = '0;
    for (int k = 0; k < NSECT; k++) if (oh[k]) r = r | SIDX_W'(k);
    return r;
  endfunction

endpackage

// File: rtl/sector_span_dec.sv
module sector_span_dec
  import sector_lock_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        op,
  output logic [NSECT-1:0]  span
);

  logic [31:0] a_w;
  logic [31:0] sz_w;
  logic [31:0] lo_w;
  logic [31:0] hi_w;

  always_comb begin
    a_w  = 32'(addr);
    sz_w = blk_bytes(op);
    lo_w = a_w & ~(sz_w - 32'd1);
    hi_w = lo_w + sz_w - 32'd1;
  end

  // One overlap comparator pair per sector, bounds fixed at elaboration.
  for (genvar i = 0; i < NSECT; i++) begin : g_sect
    localparam logic [31:0] S_LO = sect_lo(i);
    localparam logic [31:0] S_HI = sect_hi(i);
    assign span[i] = (S_LO <= hi_w) && (S_HI >= lo_w);
  end

endmodule

// File: rtl/prot_bank.sv
module prot_bank
  import sector_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             all_set,
  input  logic             all_clr,
  input  logic             one_set,
  input  logic             one_clr,
  input  logic [NSECT-1:0] tgt_mask,
  output logic [NSECT-1:0] prot_q,
  output logic [NSECT-1:0] set_mask,
  output logic [NSECT-1:0] clr_mask
);

  logic [NSECT-1:0] prot_d;

  // Precedence: global set, unlocked global clear, single set, unlocked single clear.
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (all_set) begin
      set_mask = '1;
    end else if (all_clr && wp_n) begin
      clr_mask = '1;
    end else if (one_set) begin
      set_mask = tgt_mask;
    end else if (one_clr && wp_n) begin
      clr_mask = tgt_mask;
    end
    prot_d = (prot_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prot_q <= '1;
    else        prot_q <= prot_d;
  end

endmodule

// File: rtl/verdict_stage.sv
module verdict_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_req,
  input  logic blocked,
  input  logic err_clr,
  output logic res_valid,
  output logic res_allow,
  output logic err_flag
);

  logic deny_now;
  assign deny_now = chk_req && blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_allow <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      res_valid <= chk_req;
      res_allow <= chk_req && !blocked;
      err_flag  <= deny_now || (err_flag && !err_clr);
    end
  end

endmodule

// File: rtl/sector_lock_unit.sv
module sector_lock_unit
  import sector_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              sect_prot_req,
  input  logic              sect_unprot_req,
  input  logic [ADDR_W-1:0] sect_addr,
  input  logic              all_prot_req,
  input  logic              all_unprot_req,
  input  logic              chk_req,
  input  logic [2:0]        chk_op,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              err_clr,
  output logic [SIDX_W-1:0] sect_idx,
  output logic              sect_prot,
  output logic              res_valid,
  output logic              res_allow,
  output logic              err_flag
);

  localparam int NDEC = 3;

  logic [ADDR_W-1:0] dec_addr [NDEC];
  logic [2:0]        dec_op   [NDEC];
  logic [NSECT-1:0]  dec_span [NDEC];

  // Decoder 0: span of the checked operation, 1: home sector of the check
  // address, 2: home sector of the single protect/unprotect address.
  assign dec_addr[0] = chk_addr;
  assign dec_op[0]   = chk_op;
  assign dec_addr[1] = chk_addr;
  assign dec_op[1]   = OP_PROG;
  assign dec_addr[2] = sect_addr;
  assign dec_op[2]   = OP_PROG;

  for (genvar g = 0; g < NDEC; g++) begin : g_dec
    sector_span_dec u_dec (
      .addr (dec_addr[g]),
      .op   (dec_op[g]),
      .span (dec_span[g])
    );
  end

  logic [NSECT-1:0] chk_span;
  logic [NSECT-1:0] chk_home;
  logic [NSECT-1:0] tgt_home;
  logic [NSECT-1:0] prot_q;
  logic [NSECT-1:0] set_mask;
  logic [NSECT-1:0] clr_mask;
  logic             blocked;

  assign chk_span = dec_span[0];
  assign chk_home = dec_span[1];
  assign tgt_home = dec_span[2];

  prot_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .all_set  (all_prot_req),
    .all_clr  (all_unprot_req),
    .one_set  (sect_prot_req),
    .one_clr  (sect_unprot_req),
    .tgt_mask (tgt_home),
    .prot_q   (prot_q),
    .set_mask (set_mask),
    .clr_mask (clr_mask)
  );

  assign blocked   = |(chk_span & prot_q);
  assign sect_prot = |(chk_home & prot_q);
  assign sect_idx  = onehot_to_idx(chk_home);

  verdict_stage u_verdict (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_req   (chk_req),
    .blocked   (blocked),
    .err_clr   (err_clr),
    .res_valid (res_valid),
    .res_allow (res_allow),
    .err_flag  (err_flag)
  );

endmodule

// File: rtl/sector_lock_chk.sv
module sector_lock_chk
  import sector_lock_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wp_n,
  input logic             all_prot_req,
  input logic             chk_req,
  input logic             err_clr,
  input logic             err_flag,
  input logic             res_valid,
  input logic             res_allow,
  input logic             blocked,
  input logic [NSECT-1:0] prot_q,
  input logic [NSECT-1:0] chk_home,
  input logic [NSECT-1:0] clr_mask
);

  // R2
  home_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chk_home) == 1);

  // R5
  all_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_prot_req |=> (&prot_q));

  // R6
  wp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> (($past(prot_q) & ~prot_q) == '0));

  // R6
  wp_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |-> (clr_mask == '0));

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> res_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_req |=> !res_valid);

  // R8
  allow_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_allow |-> res_valid);

  // R11
  deny_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && blocked) |=> (err_flag && !res_allow));

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

endmodule

bind sector_lock_unit sector_lock_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wp_n         (wp_n),
  .all_prot_req (all_prot_req),
  .chk_req      (chk_req),
  .err_clr      (err_clr),
  .err_flag     (err_flag),
  .res_valid    (res_valid),
  .res_allow    (res_allow),
  .blocked      (blocked),
  .prot_q       (prot_q),
  .chk_home     (chk_home),
  .clr_mask     (clr_mask)
);

// File: tb/sector_lock_unit_tb.sv
`timescale 1ns/1ps
module sector_lock_unit_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, wp_n, sp, su, ap, au, cq, ec;
  logic [18:0] sa, ca;
  logic [2:0]  co;
  wire  [3:0]  sidx;
  wire         sprot, rv, ra, ef;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [10:0] mdl;
  bit merr;

  sector_lock_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .sect_prot_req(sp), .sect_unprot_req(su), .sect_addr(sa),
    .all_prot_req(ap), .all_unprot_req(au),
    .chk_req(cq), .chk_op(co), .chk_addr(ca), .err_clr(ec),
    .sect_idx(sidx), .sect_prot(sprot),
    .res_valid(rv), .res_allow(ra), .err_flag(ef)
  );

  function automatic int sec_of(int a);
    if (a < 'h70000) return a / 65536;
    if (a < 'h78000) return 7;
    if (a < 'h7A000) return 8;
    if (a < 'h7C000) return 9;
    return 10;
  endfunction

  function automatic int base_of(int s);
    case (s)
      7: return 'h70000;
      8: return 'h78000;
      9: return 'h7A000;
      10: return 'h7C000;
      default: return s * 65536;
    endcase
  endfunction

  function automatic bit model_blocked(int op, int a);
    int sz, lo, hi;
    bit b;
    case (op)
      0: sz = 1;
      1: sz = 4096;
      2: sz = 32768;
      3: sz = 65536;
      default: sz = 524288;
    endcase
    lo = a - (a % sz);
    hi = lo + sz - 1;
    b = 0;
    for (int s = sec_of(lo); s <= sec_of(hi); s++) if (mdl[s]) b = 1;
    return b;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    sp = 0; su = 0; ap = 0; au = 0; cq = 0; ec = 0;
  endtask

  // One cycle with the currently driven requests, checked against the model.
  task automatic step(string tag);
    bit had_chk, exp_allow;
    had_chk = cq;
    exp_allow = 1;
    if (cq) exp_allow = !model_blocked(int'(co), int'(ca));
    merr = (had_chk && !exp_allow) || (merr && !ec);
    if (ap) mdl = '1;
    else if (au && wp_n) mdl = '0;
    else if (sp) mdl[sec_of(int'(sa))] = 1'b1;
    else if (su && wp_n) mdl[sec_of(int'(sa))] = 1'b0;
    tick();
    check(tag, "res_valid", int'(rv), int'(had_chk));
    if (had_chk) check(tag, "res_allow", int'(ra), int'(exp_allow));
    check(tag, "err_flag", int'(ef), int'(merr));
  endtask

  task automatic verify_bits(string tag);
    logic [10:0] v;
    for (int s = 0; s < 11; s++) begin
      ca = 19'(base_of(s));
      #0.1;
      v[s] = sprot;
    end
    check(tag, "protection bits", int'(v), int'(mdl));
  endtask

  task automatic do_chk(string tag, int op, int a);
    cq = 1; co = 3'(op); ca = 19'(a);
    step(tag);
  endtask

  task automatic t_reset();
    rst_n = 0; wp_n = 1; sp = 0; su = 0; ap = 0; au = 0; cq = 0; ec = 0;
    sa = '0; ca = '0; co = '0;
    mdl = '1; merr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "err_flag", int'(ef), 0);
    check("R1", "res_valid", int'(rv), 0);
    verify_bits("R1");
  endtask

  task automatic t_map();
    int addrs [12] = '{'h00000, 'h0FFFF, 'h10000, 'h6FFFF, 'h70000, 'h77FFF,
                       'h78000, 'h79FFF, 'h7A000, 'h7BFFF, 'h7C000, 'h7FFFF};
    foreach (addrs[k]) begin
      ca = 19'(addrs[k]);
      #0.1;
      check("R2", "sect_idx", int'(sidx), sec_of(addrs[k]));
    end
  endtask

  task automatic t_single();
    au = 1; step("R5"); verify_bits("R5");
    sp = 1; sa = 19'h79FFF; step("R3"); verify_bits("R3");
    sp = 1; sa = 19'h30000; step("R3"); verify_bits("R3");
    su = 1; sa = 19'h30123; step("R4"); verify_bits("R4");
  endtask

  task automatic t_global();
    ap = 1; step("R5"); verify_bits("R5");
    au = 1; step("R5"); verify_bits("R5");
  endtask

  task automatic t_wp();
    ap = 1; step("R6");
    wp_n = 0;
    au = 1; step("R6"); verify_bits("R6");
    su = 1; sa = 19'h20000; step("R6"); verify_bits("R6");
    wp_n = 1;
    au = 1; step("R6"); verify_bits("R6");
    wp_n = 0;
    sp = 1; sa = 19'h7B000; step("R6"); verify_bits("R6");
    wp_n = 1;
  endtask

  task automatic t_prio();
    ap = 1; au = 1; step("R7"); verify_bits("R7");
    au = 1; step("R7");
    sp = 1; su = 1; sa = 19'h7C000; step("R7"); verify_bits("R7");
    au = 1; sp = 1; sa = 19'h00000; step("R7"); verify_bits("R7");
    wp_n = 0;
    au = 1; sp = 1; sa = 19'h00000; step("R7"); verify_bits("R7");
    wp_n = 1;
  endtask

  task automatic t_prog();
    do_chk("R8", 0, 'h00100);
    do_chk("R8", 0, 'h10000);
    do_chk("R8", 1, 'h0FFFF);
    do_chk("R8", 1, 'h7F000);
    step("R8");
  endtask

  task automatic t_block();
    au = 1; step("R9");
    sp = 1; sa = 19'h7C000; step("R9");
    do_chk("R9", 2, 'h7F000);
    do_chk("R9", 2, 'h7A100);
    do_chk("R9", 2, 'h70000);
    do_chk("R9", 3, 'h60000);
    do_chk("R9", 3, 'h70000);
    au = 1; step("R9");
    sp = 1; sa = 19'h77FFF; step("R9");
    do_chk("R9", 2, 'h78000);
    do_chk("R9", 2, 'h77000);
  endtask

  task automatic t_chip();
    do_chk("R10", 4, 'h00000);
    au = 1; step("R10");
    do_chk("R10", 4, 'h12345);
    sp = 1; sa = 19'h00000; step("R10");
    do_chk("R10", 7, 'h7FFFF);
  endtask

  task automatic t_err();
    ec = 1; step("R11");
    step("R11");
    do_chk("R11", 0, 'h00010);
    step("R11");
    ec = 1; cq = 1; co = 3'd0; ca = 19'h00020; step("R11");
    step("R11");
    ec = 1; step("R11");
  endtask

  task automatic t_same();
    au = 1; step("R12");
    cq = 1; co = 3'd0; ca = 19'h50000; sp = 1; sa = 19'h50000; step("R12");
    do_chk("R12", 0, 'h50000);
    verify_bits("R12");
    ec = 1; step("R12");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_map();
    @(negedge clk);
    t_single();
    @(negedge clk);
    t_global();
    @(negedge clk);
    t_wp();
    @(negedge clk);
    t_prio();
    @(negedge clk);
    t_prog();
    t_block();
    t_chip();
    t_err();
    t_same();
    finish_run();
  end

endmodule